// File: doc/BRIEF.md
# Dual-Group Clock Divider with Phase Stepping

This block divides one fast reference clock into two output clocks, one per output group. Each group has its own post-divide ratio, chosen from a fixed set of eleven values by a 4-bit code. The clock of group 1 can be delayed against group 0 by a programmable number of phase steps. The number of steps available for a ratio P is P/5 when P is a multiple of 5 and P otherwise, so the full set of steps always spans one output period.

New settings are presented on the inputs and take effect only when `load` is pulsed. An accepted load then restarts both group counters on the same fast-clock edge, so the phase relation between the groups is fixed. Each group also carries a bypass select, latched on the same load. It tells an external mux to route the input reference to that group in place of the divided clock.

A small controller sequences the block through three states. `S_INIT` is entered on reset and issues the first restart. The `init_done` transition then moves to `S_RUN`, where the counters run freely. An accepted load takes the `load_accept` transition into `S_LOAD`, which restarts both counters. From `S_LOAD` the `load_done` transition returns to `S_RUN`, or the `load_again` transition stays in `S_LOAD` when a further accepted load arrives.

Top module: `clkdiv_phase_top`

## Requirements
- R1: Ratio codes 0..10 select P = 1, 2, 4, 5, 8, 10, 16, 20, 32, 40, 80 respectively. For P of 2 or more, a group output rises once every P fast-clock cycles.
- R2: For P of 2 or more, a group output stays high for (P+1)/2 fast cycles (rounded down) in each period, so for odd P the high part is the longer half.
- R3: With P = 1 (code 0), the group output equals the fast clock.
- R4: A load in which either group's code is above 10 is ignored as a whole. Ratios, phase step and bypass selects stay unchanged, and no restart occurs.
- R5: Changes on the ratio, step and bypass inputs have no effect while `load` is low.
- R6: After an accepted load sampled at edge L, both counters restart at edge L+1. Group 0's output is high after edge L+2, and group 1 with step s > 0 is low at that point whenever its restart count falls in its low half.
- R7: With equal ratios in both groups, the rising edge of group 1 trails that of group 0 by s×5 fast cycles when P is a multiple of 5, and by s fast cycles otherwise.
- R8: A step value s of n or more, where n = P/5 for multiples of 5 and n = P otherwise (n taken from group 1's new ratio), is treated as n−1.
- R9: A step of 0 with equal ratios gives coincident rising edges in both groups.
- R10: `grp_bypass[g]` takes the value of `bypass_req[g]` from the last accepted load.
- R11: During reset both group outputs and both bypass selects are low. After reset both groups run at P = 2 with step 0 and bypass off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Strobe that applies the ratio, step and bypass inputs |
| grp0_ratio | input | 4 | Ratio code for group 0 (0..10 valid) |
| grp1_ratio | input | 4 | Ratio code for group 1 (0..10 valid) |
| phase_step | input | 7 | Delay of group 1 in phase steps |
| bypass_req | input | 2 | Requested bypass select, bit g for group g |
| grp_clk | output | 2 | Divided clock, bit g for group g |
| grp_bypass | output | 2 | Latched bypass select, bit g for group g |

## Verification
The bench sweeps every ratio code through every step value plus one step past the range, and measures the rising-edge offset between the two outputs at the ports. A design that preloaded the wrong counter, or omitted the factor of 5 for ratios that are multiples of 5, would show an offset off by a factor of 5 or wrap to a different value. Saturation is probed at exactly n and at the largest input value; a design without it would wrap the step around and report a small or zero offset. Loads with an out-of-range code and input changes without a load are checked by confirming that the old period and bypass selects survive. The restart timing and the pass-through at ratio 1 are checked directly, which catches a design that restarts the groups on different edges or divides by 1 with a counter.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 7;

    typedef enum logic [1:0] {S_INIT, S_RUN, S_LOAD} ctrl_state_e;

    function automatic logic [CNT_W-1:0] ratio_of(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] p;
        unique case (code)
            4'd0:    p = 7'd1;
            4'd1:    p = 7'd2;
            4'd2:    p = 7'd4;
            4'd3:    p = 7'd5;
            4'd4:    p = 7'd8;
            4'd5:    p = 7'd10;
            4'd6:    p = 7'd16;
            4'd7:    p = 7'd20;
            4'd8:    p = 7'd32;
            4'd9:    p = 7'd40;
            4'd10:   p = 7'd80;
            default: p = 7'd0;
        endcase
        return p;
    endfunction

    function automatic logic code_ok(input logic [CODE_W-1:0] code);
        return code <= 4'd10;
    endfunction

    function automatic logic is_m5(input logic [CNT_W-1:0] p);
        return (p != '0) && ((p % 7'd5) == '0);
    endfunction

    function automatic logic [CNT_W-1:0] steps_of(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] p;
        p = ratio_of(code);
        return is_m5(p) ? p / 7'd5 : p;
    endfunction
endpackage

// File: rtl/clkdiv_ctrl.sv
`timescale 1ns/1ps
module clkdiv_ctrl
    import clkdiv_pkg::*;
#(
    parameter int STEP_W = 7,
    parameter int NGRP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in0,
    input  logic [CODE_W-1:0] code_in1,
    input  logic [STEP_W-1:0] step_in,
    input  logic [NGRP-1:0]   byp_in,
    output logic              sync,
    output logic [CODE_W-1:0] code0_q,
    output logic [CODE_W-1:0] code1_q,
    output logic [CNT_W-1:0]  step_q,
    output logic [NGRP-1:0]   byp_q
);
    ctrl_state_e state, nxt;
    logic        codes_ok, accept;
    logic [CNT_W-1:0] n1, step_sat;

    assign codes_ok = code_ok(code_in0) && code_ok(code_in1);
    assign accept   = load && codes_ok && (state != S_INIT);

    always_comb begin
        n1 = steps_of(code_in1);
        if (int'(step_in) >= int'(n1)) step_sat = n1 - 7'd1;
        else                           step_sat = CNT_W'(step_in);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_INIT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_INIT: nxt = S_RUN;                       // init_done
            S_RUN:  if (accept) nxt = S_LOAD;          // load_accept
            S_LOAD: nxt = accept ? S_LOAD : S_RUN;     // load_again / load_done
            default: nxt = S_INIT;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            S_RUN:   sync = 1'b0;
            default: sync = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code0_q <= 4'd1;
            code1_q <= 4'd1;
            step_q  <= '0;
            byp_q   <= '0;
        end else if (accept) begin
            code0_q <= code_in0;
            code1_q <= code_in1;
            step_q  <= step_sat;
            byp_q   <= byp_in;
        end
    end

    p_load_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && codes_ok && state != S_INIT) |=> (state == S_LOAD));
    p_bad_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !codes_ok) |=> ($stable(code0_q) && $stable(code1_q) && $stable(step_q) && $stable(byp_q)));
    p_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(code0_q) && $stable(code1_q) && $stable(step_q) && $stable(byp_q)));
    p_step_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_q < steps_of(code1_q));
endmodule

// File: rtl/clkdiv_group.sv
`timescale 1ns/1ps
module clkdiv_group
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync,
    input  logic [CODE_W-1:0] code,
    input  logic [CNT_W-1:0]  step,
    output logic              div_q,
    output logic              clk_out
);
    logic [CNT_W-1:0] p, modn, half, main_cnt, cyc;
    logic [2:0]       pre_cnt, pre_last;
    logic             m5, pass;

    always_comb begin
        p        = ratio_of(code);
        m5       = is_m5(p);
        modn     = m5 ? p / 7'd5 : p;
        pre_last = m5 ? 3'd4 : 3'd0;
        half     = (p + 7'd1) >> 1;
        pass     = (p == 7'd1);
        cyc      = m5 ? (main_cnt * 7'd5 + {4'b0, pre_cnt}) : main_cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            main_cnt <= '0;
            div_q    <= 1'b0;
        end else begin
            div_q <= (cyc < half);
            if (sync) begin
                pre_cnt  <= '0;
                main_cnt <= (step == '0) ? '0 : modn - step;
            end else if (pre_cnt == pre_last) begin
                pre_cnt  <= '0;
                main_cnt <= (main_cnt == modn - 7'd1) ? '0 : main_cnt + 7'd1;
            end else begin
                pre_cnt <= pre_cnt + 3'd1;
            end
        end
    end

    assign clk_out = pass ? clk : div_q;

    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |-> (main_cnt < modn && pre_cnt <= pre_last));
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync && pre_cnt == pre_last && main_cnt == modn - 7'd1) |=> (main_cnt == '0 && pre_cnt == '0));
    p_out_low_rst_r11: assert property (@(posedge clk)
        !rst_n |-> !div_q);
endmodule

// File: rtl/clkdiv_phase_top.sv
`timescale 1ns/1ps
module clkdiv_phase_top
    import clkdiv_pkg::*;
#(
    parameter int STEP_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] grp0_ratio,
    input  logic [CODE_W-1:0] grp1_ratio,
    input  logic [STEP_W-1:0] phase_step,
    input  logic [1:0]        bypass_req,
    output logic [1:0]        grp_clk,
    output logic [1:0]        grp_bypass
);
    localparam int NGRP = 2;

    logic              sync;
    logic [CODE_W-1:0] code_q [NGRP];
    logic [CNT_W-1:0]  step_q;
    logic [NGRP-1:0]   div_q;

    clkdiv_ctrl #(.STEP_W(STEP_W), .NGRP(NGRP)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .code_in0 (grp0_ratio),
        .code_in1 (grp1_ratio),
        .step_in  (phase_step),
        .byp_in   (bypass_req),
        .sync     (sync),
        .code0_q  (code_q[0]),
        .code1_q  (code_q[1]),
        .step_q   (step_q),
        .byp_q    (grp_bypass)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [CNT_W-1:0] gstep;
        assign gstep = (g == 0) ? '0 : step_q;
        clkdiv_group u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync    (sync),
            .code    (code_q[g]),
            .step    (gstep),
            .div_q   (div_q[g]),
            .clk_out (grp_clk[g])
        );
    end

    p_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q[0] == code_q[1] && step_q == '0 && !sync && !$past(sync)) |-> (div_q[0] == div_q[1]));
endmodule

// File: tb/clkdiv_phase_top_tb.sv
`timescale 1ns/1ps
module clkdiv_phase_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic [3:0] r0 = 4'd1, r1 = 4'd1;
    logic [6:0] st = '0;
    logic [1:0] breq = '0;
    logic [1:0] gclk, gbyp;

    always #10 clk = ~clk;

    clkdiv_phase_top u_dut (
        .clk(clk), .rst_n(rst_n), .load(load),
        .grp0_ratio(r0), .grp1_ratio(r1), .phase_step(st),
        .bypass_req(breq), .grp_clk(gclk), .grp_bypass(gbyp)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // code, expected ratio, step unit
    localparam int NV = 10;
    localparam int V_CODE [NV] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10};
    localparam int V_P    [NV] = '{2, 4, 5, 8, 10, 16, 20, 32, 40, 80};
    localparam int V_K    [NV] = '{1, 1, 5, 1, 5, 1, 5, 1, 5, 5};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_load(input int c0, input int c1, input int s, input logic [1:0] b);
        @(negedge clk);
        r0 = 4'(c0); r1 = 4'(c1); st = 7'(s); breq = b; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic measure(input int p, output int off, output int hi, output int per);
        int t0, t1, tf, tn;
        bit p0, p1;
        t0 = -1; t1 = -1; tf = -1; tn = -1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        p0 = gclk[0]; p1 = gclk[1];
        for (int i = 1; i < 4 * p + 8; i++) begin
            @(negedge clk);
            if (t0 < 0 && !p0 && gclk[0]) t0 = i;
            else if (t0 >= 0 && tn < 0 && !p0 && gclk[0]) tn = i;
            if (t0 >= 0 && t1 < 0 && !p1 && gclk[1]) t1 = i;
            if (t0 >= 0 && i > t0 && tf < 0 && p0 && !gclk[0]) tf = i;
            p0 = gclk[0]; p1 = gclk[1];
        end
        off = (t0 < 0 || t1 < 0) ? -1 : t1 - t0;
        hi  = (t0 < 0 || tf < 0) ? -1 : tf - t0;
        per = (t0 < 0 || tn < 0) ? -1 : tn - t0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int off, hi, per, n, s_exp;
        // R11 reset state
        repeat (4) @(negedge clk);
        chk(gclk == 2'b00, "R11 outputs low in reset", int'(gclk), 0);
        chk(gbyp == 2'b00, "R11 bypass low in reset", int'(gbyp), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        measure(2, off, hi, per);
        chk(per == 2, "R11 default period", per, 2);
        chk(off == 0, "R11 default step", off, 0);

        // table sweep: every ratio, every step, plus one past the range
        for (int v = 0; v < NV; v++) begin
            n = V_P[v] / V_K[v];
            for (int s = 0; s <= n; s++) begin
                do_load(V_CODE[v], V_CODE[v], s, 2'b00);
                measure(V_P[v], off, hi, per);
                s_exp = (s < n) ? s : n - 1;
                if (s == n) chk(off == s_exp * V_K[v], "R8 saturated step", off, s_exp * V_K[v]);
                else if (s == 0) chk(off == 0, "R9 aligned edges", off, 0);
                else chk(off == s_exp * V_K[v], "R7 phase offset", off, s_exp * V_K[v]);
                if (s == 0) begin
                    chk(per == V_P[v], "R1 period", per, V_P[v]);
                    chk(hi == (V_P[v] + 1) / 2, "R2 high length", hi, (V_P[v] + 1) / 2);
                end
            end
        end

        // R8 largest step on P=10
        do_load(5, 5, 127, 2'b00);
        measure(10, off, hi, per);
        chk(off == 5, "R8 step 127 on P=10", off, 5);

        // R6 restart timing: P=4, group1 step 1 starts in its low half
        do_load(2, 2, 0, 2'b00);
        repeat (6) @(negedge clk);
        do_load(2, 2, 1, 2'b00);
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(gclk[0] == 1'b1, "R6 group0 high after restart", int'(gclk[0]), 1);
        chk(gclk[1] == 1'b0, "R6 group1 low after restart", int'(gclk[1]), 0);

        // R3 ratio 1 pass-through
        do_load(0, 0, 0, 2'b00);
        repeat (4) @(negedge clk);
        @(posedge clk); #5;
        chk(gclk == 2'b11, "R3 pass-through high", int'(gclk), 3);
        @(negedge clk); #5;
        chk(gclk == 2'b00, "R3 pass-through low", int'(gclk), 0);

        // R10 bypass latch
        do_load(1, 1, 0, 2'b10);
        @(negedge clk);
        chk(gbyp == 2'b10, "R10 bypass select", int'(gbyp), 2);

        // R4 invalid codes ignored
        do_load(12, 3, 0, 2'b01);
        @(negedge clk);
        chk(gbyp == 2'b10, "R4 bad code0 keeps bypass", int'(gbyp), 2);
        measure(2, off, hi, per);
        chk(per == 2, "R4 bad code0 keeps ratio", per, 2);
        do_load(3, 11, 0, 2'b11);
        @(negedge clk);
        chk(gbyp == 2'b10, "R4 bad code1 keeps bypass", int'(gbyp), 2);
        measure(2, off, hi, per);
        chk(per == 2, "R4 bad code1 keeps ratio", per, 2);

        // R5 inputs without load
        @(negedge clk);
        r0 = 4'd4; r1 = 4'd5; st = 7'd3; breq = 2'b01;
        repeat (5) @(negedge clk);
        chk(gbyp == 2'b10, "R5 bypass unchanged", int'(gbyp), 2);
        measure(2, off, hi, per);
        chk(per == 2, "R5 ratio unchanged", per, 2);
        chk(off == 0, "R5 step unchanged", off, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule